// File: doc/BRIEF.md
# Priority Reference Selector with Revertivity

This block picks which of twelve candidate timing references drives one clock generator. A host chooses between two modes. In manual mode a host-written index names the reference directly, and the input's qualification state is not consulted. In automatic mode the selector chooses among the qualified inputs using a per-input priority table, and a revertive enable decides what happens when a better reference becomes available.

The priority table belongs to this instance only. A second clock generator uses its own copy of the block and its own table. With revertive operation the output always follows the best qualified input. Without it, the current reference is kept for as long as it stays usable, and a new choice is made only when it fails. When nothing is usable, the valid flag drops and the last index is held, so the downstream loop can enter holdover. A one-cycle pulse marks every change of the active index.

Top module: `ref_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `active_idx_o` is 0, `active_valid_o` is 0 and `switch_pulse_o` is 0.
- R2: In manual mode (`auto_mode_i`=0) with `manual_idx_i` below 12, the output one clock later shows that index with valid high, whatever the qualification bits are.
- R3: In manual mode with `manual_idx_i` of 12 or more, the active index is held and valid goes low one clock later.
- R4: The priority of input i sits in `prio_i[4*i+3:4*i]`. A lower nonzero value is preferred, and the value 0 excludes the input from automatic selection even when it is qualified.
- R5: When qualified, eligible inputs share the best priority value, the lowest index among them is chosen.
- R6: In automatic mode with `revertive_i`=1, the active index one clock later is the best eligible qualified input, including when a better input returns.
- R7: In automatic mode with `revertive_i`=0, if the current active input is qualified and has a nonzero priority, the index is kept and valid stays high, even when a better input is qualified.
- R8: In automatic mode with `revertive_i`=0, if the current input is unqualified or has priority 0, the selector moves to the best eligible qualified input one clock later.
- R9: In automatic mode with no input both qualified and of nonzero priority, valid goes low and the index is held.
- R10: `switch_pulse_o` is high for exactly the one cycle in which a changed `active_idx_o` first appears, and is low in every other cycle.
- R11: In automatic mode, whenever valid is high the active input was qualified on the clock edge that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| qual_i | input | 12 | Qualification flag for each input |
| prio_i | input | 48 | Priority table, 4 bits per input, 0 means excluded |
| auto_mode_i | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| manual_idx_i | input | 4 | Host-chosen index used in manual mode |
| revertive_i | input | 1 | Revertive enable for automatic mode |
| active_idx_o | output | 4 | Active reference index |
| active_valid_o | output | 1 | Active index is usable |
| switch_pulse_o | output | 1 | One-cycle pulse when the active index changes |

## Verification
The bench targets the cases where a selector that looks plausible is still wrong. A tie on priority must go to the lower index, and a design that scans in the wrong direction lands on the higher one. A qualified input with priority 0 must never be taken, and a design that treats 0 as the top priority grabs it. With revertive operation off, a better input that returns must be ignored, and a design that always re-picks the best input would switch away from a healthy reference. Manual selection of an unqualified input must still be honoured, and the switch pulse must not fire when the index does not change. Loss of every usable input must hold the index with valid low, not reset the index to zero.

// File: rtl/ref_sel_pkg.sv
// Package: shared decision encoding for the reference selector.
// Assumes: consumers hold index/valid state in registers outside the decision logic.
package ref_sel_pkg;

    // What the register stage should do with the active index this cycle.
    typedef enum logic [1:0] {
        SEL_HOLD   = 2'd0,  // keep index, valid high
        SEL_MANUAL = 2'd1,  // load host index, valid high
        SEL_BEST   = 2'd2,  // load best eligible index, valid high
        SEL_LOST   = 2'd3   // keep index, valid low
    } sel_action_e;

endpackage

// File: rtl/ref_sel_best.sv
// Module: ref_sel_best
// Finds the best qualified, eligible input from a flat priority table and reports
// whether the currently active input is itself still usable.
// Assumes: priority 0 means excluded; lower nonzero value wins; ties go to lower index.
module ref_sel_best #(
    parameter int N_REF  = 12,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_REF)
) (
    input  logic [N_REF-1:0]        qual_i,
    input  logic [N_REF*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]        cur_idx_i,
    output logic [IDX_W-1:0]        best_idx_o,
    output logic                    best_found_o,
    output logic                    cur_usable_o
);

    logic [N_REF-1:0] eligible;

    // Per-input eligibility: qualified and not excluded by priority 0.
    generate
        for (genvar g = 0; g < N_REF; g++) begin : g_elig
            assign eligible[g] = qual_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
        end
    endgenerate

    // Linear search; strict compare keeps the lowest index on a tie.
    always_comb begin
        logic [PRIO_W-1:0] best_prio;
        best_prio    = '1;
        best_idx_o   = '0;
        best_found_o = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (eligible[i] &&
                (!best_found_o || (prio_i[i*PRIO_W +: PRIO_W] < best_prio))) begin
                best_prio    = prio_i[i*PRIO_W +: PRIO_W];
                best_idx_o   = IDX_W'(i);
                best_found_o = 1'b1;
            end
        end
    end

    // Usability of the currently active input, without a dynamic bit select.
    always_comb begin
        cur_usable_o = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (cur_idx_i == IDX_W'(i)) begin
                cur_usable_o = eligible[i];
            end
        end
    end

endmodule

// File: rtl/ref_sel_decide.sv
// Module: ref_sel_decide
// Turns mode, revertive setting and search results into one register action.
// Assumes: search results refer to the same cycle's inputs and current index.
module ref_sel_decide
    import ref_sel_pkg::*;
#(
    parameter int N_REF = 12,
    parameter int IDX_W = $clog2(N_REF)
) (
    input  logic              auto_mode_i,
    input  logic              revertive_i,
    input  logic [IDX_W-1:0]  manual_idx_i,
    input  logic              best_found_i,
    input  logic              cur_usable_i,
    output sel_action_e       action_o
);

    logic manual_in_range;

    // Host index must name an existing input.
    assign manual_in_range = (int'(manual_idx_i) < N_REF);

    // Mode and revertivity rules, in priority order.
    always_comb begin
        if (!auto_mode_i) begin
            action_o = manual_in_range ? SEL_MANUAL : SEL_LOST;
        end else if (!best_found_i) begin
            action_o = SEL_LOST;
        end else if (revertive_i) begin
            action_o = SEL_BEST;
        end else if (cur_usable_i) begin
            action_o = SEL_HOLD;
        end else begin
            action_o = SEL_BEST;
        end
    end

endmodule

// File: rtl/ref_selector.sv
// Module: ref_selector (top)
// Registers the active reference index, its valid flag and a change pulse.
// Assumes: all inputs are synchronous to clk; one clock from input to output.
module ref_selector
    import ref_sel_pkg::*;
#(
    parameter int N_REF  = 12,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_REF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REF-1:0]        qual_i,
    input  logic [N_REF*PRIO_W-1:0] prio_i,
    input  logic                    auto_mode_i,
    input  logic [IDX_W-1:0]        manual_idx_i,
    input  logic                    revertive_i,
    output logic [IDX_W-1:0]        active_idx_o,
    output logic                    active_valid_o,
    output logic                    switch_pulse_o
);

    logic [IDX_W-1:0] idx_q, idx_d, best_idx;
    logic             valid_q, valid_d, pulse_q;
    logic             best_found, cur_usable;
    sel_action_e      action;

    ref_sel_best #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_best (
        .qual_i       (qual_i),
        .prio_i       (prio_i),
        .cur_idx_i    (idx_q),
        .best_idx_o   (best_idx),
        .best_found_o (best_found),
        .cur_usable_o (cur_usable)
    );

    ref_sel_decide #(.N_REF(N_REF), .IDX_W(IDX_W)) u_decide (
        .auto_mode_i  (auto_mode_i),
        .revertive_i  (revertive_i),
        .manual_idx_i (manual_idx_i),
        .best_found_i (best_found),
        .cur_usable_i (cur_usable),
        .action_o     (action)
    );

    // Apply the chosen action to form next index and valid.
    always_comb begin
        idx_d   = idx_q;
        valid_d = 1'b1;
        unique case (action)
            SEL_MANUAL: idx_d = manual_idx_i;
            SEL_BEST:   idx_d = best_idx;
            SEL_LOST:   valid_d = 1'b0;
            default:    idx_d = idx_q;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            valid_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            idx_q   <= idx_d;
            valid_q <= valid_d;
            pulse_q <= (idx_d != idx_q);
        end
    end

    assign active_idx_o   = idx_q;
    assign active_valid_o = valid_q;
    assign switch_pulse_o = pulse_q;

endmodule

// File: rtl/ref_selector_chk.sv
// Module: ref_selector_chk
// Checker for ref_selector, attached by bind; observes ports only.
// Assumes: synchronous active-low reset; properties are armed one cycle after release.
module ref_selector_chk #(
    parameter int N_REF  = 12,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_REF)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_REF-1:0]        qual_i,
    input logic [N_REF*PRIO_W-1:0] prio_i,
    input logic                    auto_mode_i,
    input logic [IDX_W-1:0]        manual_idx_i,
    input logic                    revertive_i,
    input logic [IDX_W-1:0]        active_idx_o,
    input logic                    active_valid_o,
    input logic                    switch_pulse_o
);

    logic             armed;
    logic             any_usable, cur_ok, qual_at_idx;
    logic [N_REF-1:0] qual_q;

    // Arm after one cycle out of reset and keep last cycle's qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            qual_q <= '0;
        end else begin
            armed  <= 1'b1;
            qual_q <= qual_i;
        end
    end

    // Observed usability of inputs relative to the current output index.
    always_comb begin
        any_usable  = 1'b0;
        cur_ok      = 1'b0;
        qual_at_idx = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (qual_i[i] && prio_i[i*PRIO_W +: PRIO_W] != '0) any_usable = 1'b1;
            if (active_idx_o == IDX_W'(i)) begin
                cur_ok      = qual_i[i] && prio_i[i*PRIO_W +: PRIO_W] != '0;
                qual_at_idx = qual_q[i];
            end
        end
    end

    // R2
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!auto_mode_i && int'(manual_idx_i) < N_REF)
        |-> active_idx_o == $past(manual_idx_i) && active_valid_o);

    // R9
    none_usable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i && !any_usable)
        |-> !active_valid_o && active_idx_o == $past(active_idx_o));

    // R7
    nonrev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i && !revertive_i && cur_ok)
        |-> active_valid_o && active_idx_o == $past(active_idx_o));

    // R10
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> switch_pulse_o == (active_idx_o != $past(active_idx_o)));

    // R11
    auto_valid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && active_valid_o && $past(auto_mode_i) |-> qual_at_idx);

endmodule

bind ref_selector ref_selector_chk #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .qual_i         (qual_i),
    .prio_i         (prio_i),
    .auto_mode_i    (auto_mode_i),
    .manual_idx_i   (manual_idx_i),
    .revertive_i    (revertive_i),
    .active_idx_o   (active_idx_o),
    .active_valid_o (active_valid_o),
    .switch_pulse_o (switch_pulse_o)
);

// File: tb/ref_selector_bench.sv
// Bench: behavioural model of the selection rules, compared on every clock.
module ref_selector_bench;

    localparam int NR = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] qual = '0;
    logic [47:0]   prio_flat;
    logic          auto_mode = 1'b0;
    logic [3:0]    man_idx = '0;
    logic          rev = 1'b0;
    logic [3:0]    act_idx;
    logic          act_valid, act_pulse;

    int prio_t [NR];
    int checks = 0, errors = 0;
    int m_idx = 0, m_valid = 0, m_pulse = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NR; i++) prio_flat[i*4 +: 4] = 4'(prio_t[i]);
    end

    ref_selector u_ref_selector (
        .clk            (clk),
        .rst_n          (rst_n),
        .qual_i         (qual),
        .prio_i         (prio_flat),
        .auto_mode_i    (auto_mode),
        .manual_idx_i   (man_idx),
        .revertive_i    (rev),
        .active_idx_o   (act_idx),
        .active_valid_o (act_valid),
        .switch_pulse_o (act_pulse)
    );

    function automatic bit usable(int i);
        return qual[i] && prio_t[i] != 0;
    endfunction

    // Model update for one clock edge, from the inputs held across that edge.
    task automatic model_edge();
        int nidx, nval, best;
        best = -1;
        for (int i = 0; i < NR; i++)
            if (usable(i) && (best < 0 || prio_t[i] < prio_t[best])) best = i;
        nidx = m_idx; nval = 1;
        if (!rst_n) begin
            nidx = 0; nval = 0;
        end else if (!auto_mode) begin
            if (man_idx < NR) nidx = man_idx; else nval = 0;
        end else if (best < 0) begin
            nval = 0;
        end else if (rev || !usable(m_idx)) begin
            nidx = best;
        end
        m_pulse = (rst_n && nidx != m_idx) ? 1 : 0;
        m_idx = nidx; m_valid = nval;
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (int'(act_idx) != m_idx || int'(act_valid) != m_valid || int'(act_pulse) != m_pulse) begin
            errors++;
            $display("FAIL %s idx/valid/pulse actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, act_idx, act_valid, act_pulse, m_idx, m_valid, m_pulse);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < NR; i++) prio_t[i] = 0;
        // R1: reset state and first cycle after release
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        cyc("R1");
        // R2: manual picks unqualified inputs; R10 pulse on change
        man_idx = 4'd5; cyc("R2"); cyc("R10");
        man_idx = 4'd11; qual = 12'h800; cyc("R2");
        // R3: out-of-range manual index holds index, valid low
        man_idx = 4'd13; cyc("R3"); cyc("R3");
        man_idx = 4'd11; cyc("R10");
        // R4/R5: priorities, exclusion and tie
        prio_t[1] = 0; prio_t[3] = 2; prio_t[7] = 5; prio_t[9] = 2;
        qual = '0; qual[1] = 1; qual[3] = 1; qual[7] = 1; qual[9] = 1;
        auto_mode = 1'b1; rev = 1'b1;
        cyc("R5"); cyc("R4");
        // R6: revertive returns to better input
        qual[3] = 0; cyc("R6"); cyc("R6");
        qual[3] = 1; cyc("R6"); cyc("R6");
        // R7: non-revertive keeps current despite better return
        rev = 1'b0;
        qual[3] = 0; cyc("R8");
        qual[3] = 1; cyc("R7"); cyc("R7"); cyc("R7");
        // R8: loss of current moves to best
        qual[9] = 0; cyc("R8"); cyc("R8");
        // R8: current excluded by priority 0 while qualified
        prio_t[3] = 0; cyc("R8"); cyc("R8");
        // R9: nothing usable (input 1 qualified but excluded)
        qual = '0; qual[1] = 1; cyc("R9"); cyc("R9");
        // R11: recovery picks a qualified input
        qual[9] = 1; cyc("R11"); cyc("R11");
        prio_t[3] = 2;
        // R4: priority order with larger values
        prio_t[0] = 15; prio_t[11] = 14; qual = 12'h801; rev = 1'b1; cyc("R4"); cyc("R4");
        // Mixed patterns against the model
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            qual = lfsr[11:0];
            if (lfsr[15:13] == 3'd0) auto_mode = ~auto_mode;
            if (lfsr[18:16] == 3'd0) rev = ~rev;
            man_idx = lfsr[23:20];
            if (lfsr[26:24] == 3'd1) prio_t[lfsr[30:27] % NR] = int'(lfsr[7:4]);
            cyc("MIX");
        end
        finish_run();
    end

endmodule